// File: doc/BRIEF.md
# Clock root generator with fractional M/N divider

This block produces a clock-enable stream from a fast reference clock. The stream's average rate is the reference rate scaled by a half-step pre-divider and then by an optional fractional M/N counter. Up to eight sources can be selected. Each source is modelled by one enable bit on the common reference clock, so the selected source is "running" only while its enable is high.

Software programs the block over a simple address/data write bus with a combinational read port. All writes to the divider settings land in shadow registers. Setting the commit bit copies every shadow field into the live settings on a single clock edge and restarts the division counters. The commit bit then clears itself. A root-enable bit gates the output, and a status bit reports when the root is not running.

The M/N ratio is stored in an offset-inverted form: M holds m, N holds the bitwise inverse of (n − m), and D holds the bitwise inverse of n. The hardware recovers n as (~N & mask) + m.

Top module: `clk_root_gen`

## Requirements
- R1: Registers sit at byte address 0x00 (command), 0x04 (config), 0x08 (M), 0x0C (N) and 0x10 (D). The config fields are:
  - pre-divider h in bits [HW-1:0];
  - source select in bits [10:8];
  - counter mode in bits [13:12].

  M, N and D keep only their low MNW bits. Reads return the shadow values, and bits outside the fields read 0.
- R2: Writing command bit 0 as 1 sets the update flag. The flag reads 1 after the write edge and after the next edge, on which the live settings load. It reads 0 after the edge after that.
- R3: Writes to config, M, N or D do not change the output stream until a commit loads them.
- R4: Command bits 4, 5, 6 and 7 are set by writes to config, N, M and D respectively. A commit clears all four.
- R5: The root runs only while the selected source's enable bit is 1 and either command bit 1 (root enable) or the update flag is 1. While the root is not running, root_off and command bit 31 read 1, and clk_en is 0 from the following cycle on.
- R6: Pre-divider:
  - h = 0 passes every reference cycle.
  - h ≥ 1 yields exactly 2 ticks per h+1 running reference cycles, which gives half-integer division.
- R7: Counter mode:
  - With mode ≠ 0, clk_en pulses m times per n pre-divider ticks, with n = (~N & mask) + m.
  - With mode = 0, every pre-divider tick is a pulse.
- R8: After reset the root is off, clk_en is 0, every field is 0 and the command register reads 0x80000000.
- R9: A commit clears both division accumulators, so the output pattern after a commit depends only on the new settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| src_en | input | NSRC | Per-source running enables |
| clk_en | output | 1 | Divided clock-enable pulse stream |
| root_off | output | 1 | High while the root is not running |

## Verification
On every cycle, the embedded assertions check:
- the output stays quiet after an off cycle;
- the update flag clears one edge after the load;
- the live settings move only on a load edge;
- the dirty flags drop at a commit;
- both accumulators stay within their moduli.

Only the bench's scenarios can show that the pulse counts over a window match the rate formula for several (h, m, n) choices, and that uncommitted shadow writes leave that rate unchanged. The same holds for register field placement and the inverted N encoding. A behavioural model in the bench also predicts clk_en and root_off each cycle, including the restart of the pattern after each commit.

// File: rtl/clk_root_gen.sv
module clk_root_gen #(
  parameter int HW   = 5,
  parameter int MNW  = 8,
  parameter int NSRC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_we,
  input  logic [4:0]      bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  input  logic [NSRC-1:0] src_en,
  output logic            clk_en,
  output logic            root_off
);
  localparam logic [4:0] A_CMD = 5'h00;
  localparam logic [4:0] A_CFG = 5'h04;
  localparam logic [4:0] A_M   = 5'h08;
  localparam logic [4:0] A_N   = 5'h0C;
  localparam logic [4:0] A_D   = 5'h10;
  localparam int SELW = 3;
  localparam int NSEL = 1 << SELW;
  localparam int NW   = MNW + 1;

  logic            upd_pend, loaded_q, root_en;
  logic [3:0]      dirty;
  logic [HW-1:0]   sh_h, act_h;
  logic [SELW-1:0] sh_sel, act_sel;
  logic [1:0]      sh_mode, act_mode;
  logic [MNW-1:0]  sh_m, sh_n, sh_d, act_m, act_ninv;
  logic [HW:0]     pre_acc;
  logic [NW:0]     mn_acc;
  logic [NSEL-1:0] src_vec;

  always_comb begin
    src_vec = '0;
    src_vec[NSRC-1:0] = src_en;
  end

  wire wr_cmd = bus_we && (bus_addr == A_CMD);
  wire wr_cfg = bus_we && (bus_addr == A_CFG);
  wire wr_m   = bus_we && (bus_addr == A_M);
  wire wr_n   = bus_we && (bus_addr == A_N);
  wire wr_d   = bus_we && (bus_addr == A_D);
  wire commit = upd_pend && !loaded_q;

  wire running = (root_en || upd_pend) && src_vec[act_sel];
  assign root_off = !running;

  wire [MNW-1:0] act_nm  = ~act_ninv;
  wire [NW-1:0]  act_n   = {1'b0, act_nm} + {1'b0, act_m};
  wire [NW:0]    n_ext   = {1'b0, act_n};
  wire [HW:0]    h_lim   = {1'b0, act_h} + {{HW{1'b0}}, 1'b1};
  wire [HW:0]    pre_nxt = pre_acc + {{(HW-1){1'b0}}, 2'b10};
  wire           pre_tick = (act_h == '0) || (pre_nxt >= h_lim);
  wire [NW:0]    mn_sum  = mn_acc + {2'b00, act_m};
  wire           mn_on   = (act_mode != 2'b00);
  wire           mn_hit  = (act_n == '0) || (mn_sum >= n_ext);
  wire           out_now = pre_tick && (!mn_on || mn_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upd_pend <= 1'b0;
      loaded_q <= 1'b0;
      root_en  <= 1'b0;
      dirty    <= '0;
      sh_h     <= '0;
      sh_sel   <= '0;
      sh_mode  <= '0;
      sh_m     <= '0;
      sh_n     <= '0;
      sh_d     <= '0;
      act_h    <= '0;
      act_sel  <= '0;
      act_mode <= '0;
      act_m    <= '0;
      act_ninv <= '0;
    end else begin
      if (commit) begin
        act_h    <= sh_h;
        act_sel  <= sh_sel;
        act_mode <= sh_mode;
        act_m    <= sh_m;
        act_ninv <= sh_n;
        dirty    <= '0;
        loaded_q <= 1'b1;
      end else if (loaded_q) begin
        upd_pend <= 1'b0;
        loaded_q <= 1'b0;
      end
      if (wr_cmd) begin
        root_en <= bus_wdata[1];
        if (bus_wdata[0]) upd_pend <= 1'b1;
      end
      if (wr_cfg) begin
        sh_h     <= bus_wdata[HW-1:0];
        sh_sel   <= bus_wdata[10:8];
        sh_mode  <= bus_wdata[13:12];
        dirty[0] <= 1'b1;
      end
      if (wr_n) begin
        sh_n     <= bus_wdata[MNW-1:0];
        dirty[1] <= 1'b1;
      end
      if (wr_m) begin
        sh_m     <= bus_wdata[MNW-1:0];
        dirty[2] <= 1'b1;
      end
      if (wr_d) begin
        sh_d     <= bus_wdata[MNW-1:0];
        dirty[3] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_acc <= '0;
      mn_acc  <= '0;
      clk_en  <= 1'b0;
    end else begin
      clk_en <= running && out_now;
      if (commit) begin
        pre_acc <= '0;
        mn_acc  <= '0;
      end else if (running) begin
        if (act_h != '0)
          pre_acc <= pre_tick ? (pre_nxt - h_lim) : pre_nxt;
        if (pre_tick && mn_on)
          mn_acc <= mn_hit ? ((act_n == '0) ? '0 : (mn_sum - n_ext)) : mn_sum;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CMD: begin
        bus_rdata[31]  = root_off;
        bus_rdata[7:4] = dirty;
        bus_rdata[1]   = root_en;
        bus_rdata[0]   = upd_pend;
      end
      A_CFG: begin
        bus_rdata[HW-1:0] = sh_h;
        bus_rdata[10:8]   = sh_sel;
        bus_rdata[13:12]  = sh_mode;
      end
      A_M:     bus_rdata[MNW-1:0] = sh_m;
      A_N:     bus_rdata[MNW-1:0] = sh_n;
      A_D:     bus_rdata[MNW-1:0] = sh_d;
      default: bus_rdata = '0;
    endcase
  end

  assert_off_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    root_off |=> !clk_en);

  assert_update_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (loaded_q && !(wr_cmd && bus_wdata[0])) |=> !upd_pend);

  assert_active_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable({act_h, act_sel, act_mode, act_m, act_ninv}));

  assert_dirty_cleared_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !bus_we) |=> (dirty == 4'b0000));

  assert_pre_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (act_h != '0) |-> (pre_acc < h_lim));

  assert_mn_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (act_n != '0) |-> (mn_acc < n_ext));

endmodule

// File: tb/clk_root_gen_tb.sv
module clk_root_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MASK = 255;
  localparam int HMASK = 31;
  localparam int WIN = 2520;
  localparam logic [4:0] A_CMD = 5'h00;
  localparam logic [4:0] A_CFG = 5'h04;
  localparam logic [4:0] A_M   = 5'h08;
  localparam logic [4:0] A_N   = 5'h0C;
  localparam logic [4:0] A_D   = 5'h10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  src_en = 8'hFF;
  logic        clk_en, root_off;

  int n_checks = 0, n_fail = 0, pulse_cnt = 0;
  bit model_on = 1'b0, done = 1'b0;

  int mh, msel, mmode, mm, mninv, md;
  int ah, asel, amode, am, an, pa, ma;
  bit men, mpend, mload, exp_en;

  always #(CLK_PERIOD/2) clk = ~clk;

  clk_root_gen u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_en(src_en),
    .clk_en(clk_en), .root_off(root_off)
  );

  task automatic check(bit ok, string what, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", what, act, act, exp, exp);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mh = 0; msel = 0; mmode = 0; mm = 0; mninv = 0; md = 0;
      ah = 0; asel = 0; amode = 0; am = 0; an = 0; pa = 0; ma = 0;
      men = 0; mpend = 0; mload = 0; exp_en = 0;
    end else begin
      bit run, tick, hit;
      run  = (men || mpend) && src_en[asel];
      tick = (ah == 0) || (pa + 2 >= ah + 1);
      hit  = (an == 0) || (ma + am >= an);
      exp_en = run && tick && (amode == 0 || hit);
      if (mpend && !mload) begin
        ah = mh; asel = msel; amode = mmode; am = mm;
        an = ((~mninv) & MASK) + mm;
        pa = 0; ma = 0; mload = 1;
      end else begin
        if (mload) begin mpend = 0; mload = 0; end
        if (run) begin
          if (ah != 0) pa = tick ? pa + 2 - (ah + 1) : pa + 2;
          if (tick && amode != 0) ma = hit ? ((an == 0) ? 0 : ma + am - an) : ma + am;
        end
      end
      if (bus_we) begin
        case (bus_addr)
          A_CMD: begin men = bus_wdata[1]; if (bus_wdata[0]) mpend = 1; end
          A_CFG: begin
            mh = int'(bus_wdata) & HMASK;
            msel = (int'(bus_wdata) >> 8) & 7;
            mmode = (int'(bus_wdata) >> 12) & 3;
          end
          A_M: mm = int'(bus_wdata) & MASK;
          A_N: mninv = int'(bus_wdata) & MASK;
          A_D: md = int'(bus_wdata) & MASK;
          default: ;
        endcase
      end
    end
  end

  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (rst_n && model_on) begin
      bit exp_off;
      exp_off = !((men || mpend) && src_en[asel]);
      check(clk_en == exp_en, "R6/R7/R9 clk_en vs cycle model", int'(clk_en), int'(exp_en));
      check(root_off == exp_off, "R5 root_off vs cycle model", int'(root_off), int'(exp_off));
    end
    if (clk_en) pulse_cnt++;
  end

  task automatic bus_write(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_update();
    logic [31:0] r;
    for (int i = 0; i < 10; i++) begin
      bus_read(A_CMD, r);
      if (!r[0]) break;
    end
    check(r[0] == 1'b0, "R2 update flag self-clears", int'(r[0]), 0);
  endtask

  task automatic load_shadow(int h, int sel, int mode, int m, int n);
    bus_write(A_CFG, 32'((mode << 12) | (sel << 8) | h));
    bus_write(A_M, 32'(m));
    bus_write(A_N, 32'(~(n - m) & MASK));
    bus_write(A_D, 32'(~n & MASK));
  endtask

  task automatic commit_cfg(int h, int sel, int mode, int m, int n);
    load_shadow(h, sel, mode, m, n);
    bus_write(A_CMD, 32'h3);
    wait_update();
  endtask

  task automatic rate_check(int h, int mode, int m, int n, string tag);
    int e;
    e = (h == 0) ? WIN : (WIN * 2) / (h + 1);
    if (mode != 0) e = (e * m) / n;
    @(negedge clk);
    pulse_cnt = 0;
    repeat (WIN) @(negedge clk);
    check(pulse_cnt >= e - 1 && pulse_cnt <= e + 1, tag, pulse_cnt, e);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired: actual hung expected finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_on = 1'b1;
    #1;
    check(root_off == 1'b1, "R8 root_off after reset", int'(root_off), 1);
    check(clk_en == 1'b0, "R8 clk_en after reset", int'(clk_en), 0);
    bus_read(A_CMD, r);
    check(r == 32'h8000_0000, "R8 command reset value", int'(r), 32'h8000_0000);
    bus_read(A_CFG, r);
    check(r == 32'h0, "R8 config reset value", int'(r), 0);

    bus_write(A_CFG, 32'hFFFF_2205);
    bus_read(A_CFG, r);
    check(r == 32'h0000_2205, "R1 config field placement", int'(r), 32'h2205);
    bus_write(A_M, 32'h1234_5603);
    bus_read(A_M, r);
    check(r == 32'h03, "R1 M masked to MN width", int'(r), 3);
    bus_read(A_CMD, r);
    check(r[7:4] == 4'b0101, "R4 dirty flags cfg and M", int'(r[7:4]), 5);
    check(root_off == 1'b1, "R3 shadow writes leave root off", int'(root_off), 1);

    load_shadow(2, 2, 2, 1, 3);
    bus_read(A_N, r);
    check(((~int'(r)) & MASK) + 1 == 3, "R7 n recovered from inverted N", ((~int'(r)) & MASK) + 1, 3);
    bus_read(A_D, r);
    check(r == 32'(~3 & MASK), "R1 D holds inverted n", int'(r), ~3 & MASK);
    bus_read(A_CMD, r);
    check(r[7:4] == 4'b1111, "R4 all dirty flags set", int'(r[7:4]), 15);

    bus_write(A_CMD, 32'h3);
    bus_addr = A_CMD;
    #1 check(bus_rdata[0] == 1'b1, "R2 update flag after write edge", int'(bus_rdata[0]), 1);
    @(negedge clk);
    #1 check(bus_rdata[0] == 1'b1, "R2 update flag during load edge", int'(bus_rdata[0]), 1);
    check(bus_rdata[7:4] == 4'b0, "R4 dirty flags cleared by commit", int'(bus_rdata[7:4]), 0);
    @(negedge clk);
    #1 check(bus_rdata[0] == 1'b0, "R2 update flag cleared", int'(bus_rdata[0]), 0);
    check(root_off == 1'b0, "R5 root running after enable", int'(root_off), 0);
    rate_check(2, 2, 1, 3, "R7 rate h=2 m=1 n=3");

    load_shadow(0, 2, 0, 0, 0);
    rate_check(2, 2, 1, 3, "R3 uncommitted shadow keeps rate");

    commit_cfg(0, 2, 0, 0, 1);
    rate_check(0, 0, 1, 1, "R6 bypass h=0");
    commit_cfg(3, 2, 0, 0, 1);
    rate_check(3, 0, 1, 1, "R6 divide by 2");
    commit_cfg(4, 1, 0, 0, 1);
    rate_check(4, 0, 1, 1, "R6 half-step divide by 2.5");
    commit_cfg(1, 1, 2, 3, 8);
    rate_check(1, 2, 3, 8, "R7 rate m=3 n=8");
    commit_cfg(6, 3, 2, 2, 5);
    rate_check(6, 2, 2, 5, "R7 rate h=6 m=2 n=5");
    commit_cfg(5, 3, 1, 7, 13);
    rate_check(5, 1, 7, 13, "R9 fresh pattern after commit");

    bus_write(A_CMD, 32'h0);
    #1 check(root_off == 1'b1, "R5 root_off with enable cleared", int'(root_off), 1);
    bus_read(A_CMD, r);
    check(r[31] == 1'b1, "R5 command bit 31 when off", int'(r[31]), 1);
    rate_check(5, 1, 0, 13, "R5 no pulses while disabled");

    bus_write(A_CMD, 32'h2);
    src_en = 8'hF7;
    #1 check(root_off == 1'b1, "R5 root_off with source disabled", int'(root_off), 1);
    rate_check(5, 1, 0, 13, "R5 no pulses with source disabled");
    src_en = 8'hFF;
    #1 check(root_off == 1'b0, "R5 root resumes with source enabled", int'(root_off), 0);
    repeat (20) @(negedge clk);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule